// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block combines the event sources of a UART into one active-high interrupt request and an 8-bit identification byte that software reads to learn why it was interrupted. The sources are received-data fill level, an idle timeout on the receive side, transmit-side room, receive line errors, modem-line changes, software flow-control (XOFF or special character) detection and hardware flow-line changes. Each source has its own enable bit. The identification byte shows only the most urgent pending source.

The FIFOs, the idle-timeout counter and the serial engine are outside the block. They supply fill levels, trigger codes and event strobes. Line-status and modem-status events are held until software reads the matching status register. Flow-control events and the transmit-room interrupt are acknowledged by reading the identification byte while it shows them. The transmit-room source is tracked by a three-state machine. `THR_BUSY` means there is no room. `THR_PEND` means there is room and the source has not been acknowledged. `THR_ACKED` means there is room and software has read it. The transitions are named fill (`BUSY` to `PEND` when room appears), ack (`PEND` to `ACKED` on an identification read that shows the transmit type) and drain (`PEND` or `ACKED` to `BUSY` when room disappears). A configuration bit can hold the transmit interrupt back until the shift register has also emptied.

Top module: `uirq_ident`

## Requirements
- R1: After reset the identification byte `iir` is 8'h01 and `irq` is 0.
- R2: `iir[0]` is 1 when nothing enabled is pending and 0 otherwise. `irq` equals the inverse of `iir[0]`. Both registers take their new value at the first clock edge after the source or read strobe that changes them.
- R3: `iir[7]` and `iir[6]` both copy `fifo_en`.
- R4: `iir[5:0]` holds the code of the highest pending enabled source. The order from highest to lowest, with codes, is: line error 6'h06, idle timeout 6'h0C, receive data 6'h04, transmit room 6'h02, modem change 6'h00, XOFF 6'h10, flow change 6'h20. With none pending the field is 6'h01.
- R5: Receive data is pending when `rx_level` is at least the receive threshold. When `fifo_en`=1, `rx_trig` codes 0/1/2/3 select thresholds of 8/16/56/60 characters. When `fifo_en`=0 it is pending for any nonzero level. It is enabled by `irq_en[0]`.
- R6: The idle timeout is pending while the `rx_timeout` input is high and is also enabled by `irq_en[0]`.
- R7: Transmit room exists when free space (64 minus `tx_level`) is at least the transmit threshold. When `fifo_en`=1, `tx_trig` codes 0/1/2/3 select 8/16/32/56 spaces. When `fifo_en`=0, room exists only when `tx_level` is 0. It is enabled by `irq_en[1]`.
- R8: When `thr_wait_shift`=1, transmit room exists only when `tx_level` is 0 and `tx_shift_empty` is 1.
- R9: Reading `iir` (`rd_iir`) while it shows 6'h02 acknowledges transmit room. The source stays quiet until room has first disappeared and then returned.
- R10: A pulse on `lsr_err` is held until a `rd_lsr` strobe. If a new error arrives in the same cycle as the read, the error wins.
- R11: A pulse on `msr_chg` is held until a `rd_msr` strobe.
- R12: Pulses on `xoff_evt` and `flow_evt` are each held until an `rd_iir` strobe while `iir` shows that source's code.
- R13: Enable bits `irq_en[2]` (line), `[3]` (modem), `[4]` (XOFF) and `[5]` (flow) gate their sources. A held source that is disabled neither shows in `iir` nor raises `irq`, but it stays held and appears again once it is re-enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_en | input | 6 | Source enables: 0 rx data/timeout, 1 tx room, 2 line, 3 modem, 4 XOFF, 5 flow |
| fifo_en | input | 1 | FIFO mode enable |
| rx_trig | input | 2 | Receive threshold code |
| tx_trig | input | 2 | Transmit threshold code |
| rx_level | input | LVL_W (7) | Characters held in the receive FIFO |
| tx_level | input | LVL_W (7) | Characters held in the transmit FIFO |
| tx_shift_empty | input | 1 | Transmit shift register is empty |
| thr_wait_shift | input | 1 | Hold transmit interrupt until the shift register is empty |
| rx_timeout | input | 1 | Receive idle timeout level |
| lsr_err | input | 1 | Receive line error event |
| msr_chg | input | 1 | Modem line change event |
| xoff_evt | input | 1 | XOFF or special character detected |
| flow_evt | input | 1 | Hardware flow line change |
| rd_iir | input | 1 | Identification byte read strobe |
| rd_lsr | input | 1 | Line status read strobe |
| rd_msr | input | 1 | Modem status read strobe |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
Directed patterns place the receive level one below and exactly at the highest threshold, and the transmit level one space short of and exactly at its threshold. These show whether each comparison is off by one, and in which FIFO mode. Overlapping sources are raised together and then cleared one at a time by their own strobes, which reveals the priority order and whether the right source is released. The transmit room source is acknowledged, held, drained and refilled to exercise every state of its machine. Long random runs with mixed strobes, levels, enables and trigger codes are then compared cycle by cycle against a model built from the requirements, which catches interactions the directed cases miss.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    typedef enum logic [5:0] {
        IID_MODEM  = 6'h00,
        IID_NONE   = 6'h01,
        IID_THR    = 6'h02,
        IID_RXDATA = 6'h04,
        IID_LINE   = 6'h06,
        IID_RXTO   = 6'h0C,
        IID_XOFF   = 6'h10,
        IID_FLOW   = 6'h20
    } iid_e;

    typedef enum logic [1:0] {
        THR_BUSY  = 2'd0,
        THR_PEND  = 2'd1,
        THR_ACKED = 2'd2
    } thr_state_e;

    // source index order is the priority order, index 0 highest
    localparam int NSRC       = 7;
    localparam int SRC_LINE   = 0;
    localparam int SRC_RXTO   = 1;
    localparam int SRC_RXDATA = 2;
    localparam int SRC_THR    = 3;
    localparam int SRC_MODEM  = 4;
    localparam int SRC_XOFF   = 5;
    localparam int SRC_FLOW   = 6;

endpackage

// File: rtl/uirq_level_cmp.sv
module uirq_level_cmp #(
    parameter int DEPTH = 64,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             fifo_en,
    input  logic [1:0]       rx_trig,
    input  logic [1:0]       tx_trig,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    input  logic             tx_shift_empty,
    input  logic             thr_wait_shift,
    output logic             rx_hit,
    output logic             tx_room
);

    localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);

    logic [LVL_W-1:0] rx_thr;
    logic [LVL_W-1:0] tx_thr;
    logic [LVL_W-1:0] tx_space;

    always_comb begin
        case (rx_trig)
            2'd0:    rx_thr = LVL_W'(DEPTH / 8);
            2'd1:    rx_thr = LVL_W'(DEPTH / 4);
            2'd2:    rx_thr = LVL_W'(DEPTH - 8);
            default: rx_thr = LVL_W'(DEPTH - 4);
        endcase
        case (tx_trig)
            2'd0:    tx_thr = LVL_W'(DEPTH / 8);
            2'd1:    tx_thr = LVL_W'(DEPTH / 4);
            2'd2:    tx_thr = LVL_W'(DEPTH / 2);
            default: tx_thr = LVL_W'(DEPTH - 8);
        endcase
    end

    assign tx_space = DEPTH_L - tx_level;

    always_comb begin
        rx_hit = fifo_en ? (rx_level >= rx_thr) : (rx_level != '0);
        if (thr_wait_shift)
            tx_room = (tx_level == '0) && tx_shift_empty;
        else if (fifo_en)
            tx_room = (tx_space >= tx_thr);
        else
            tx_room = (tx_level == '0);
    end

    always_comb begin
        if (rx_level == '0)
            AST_EMPTY_RX_NO_HIT: assert (!rx_hit); // R5
    end

endmodule

// File: rtl/uirq_thr_fsm.sv
module uirq_thr_fsm
    import uirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic room,
    input  logic ack,
    output logic pend_next
);

    thr_state_e state_q;
    thr_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= THR_BUSY;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            THR_BUSY:  if (room) state_d = THR_PEND;             // fill
            THR_PEND:  if (!room) state_d = THR_BUSY;            // drain
                       else if (ack) state_d = THR_ACKED;        // ack
            THR_ACKED: if (!room) state_d = THR_BUSY;            // drain
            default:   state_d = THR_BUSY;
        endcase
    end

    always_comb begin
        pend_next = (state_d == THR_PEND);
    end

    AST_THR_ACK_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && state_q == THR_PEND) |=> (state_q != THR_PEND)); // R9

endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
    import uirq_pkg::*;
(
    input  logic [NSRC-1:0] req,
    output iid_e            code
);

    function automatic iid_e src_code(input int idx);
        case (idx)
            SRC_LINE:   return IID_LINE;
            SRC_RXTO:   return IID_RXTO;
            SRC_RXDATA: return IID_RXDATA;
            SRC_THR:    return IID_THR;
            SRC_MODEM:  return IID_MODEM;
            SRC_XOFF:   return IID_XOFF;
            SRC_FLOW:   return IID_FLOW;
            default:    return IID_NONE;
        endcase
    endfunction

    always_comb begin
        code = IID_NONE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) code = src_code(i);
        end
    end

endmodule

// File: rtl/uirq_ident.sv
module uirq_ident
    import uirq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [5:0]       irq_en,
    input  logic             fifo_en,
    input  logic [1:0]       rx_trig,
    input  logic [1:0]       tx_trig,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    input  logic             tx_shift_empty,
    input  logic             thr_wait_shift,
    input  logic             rx_timeout,
    input  logic             lsr_err,
    input  logic             msr_chg,
    input  logic             xoff_evt,
    input  logic             flow_evt,
    input  logic             rd_iir,
    input  logic             rd_lsr,
    input  logic             rd_msr,
    output logic [7:0]       iir,
    output logic             irq
);

    logic       rx_hit, tx_room, thr_pend;
    logic       line_q, modem_q, xoff_q, flow_q;
    logic       line_d, modem_d, xoff_d, flow_d;
    logic       ack_thr, ack_xoff, ack_flow;
    logic [NSRC-1:0] req;
    iid_e       code;
    logic [7:0] iir_q;
    logic       irq_q;
    logic       seen_q;

    uirq_level_cmp #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_cmp (
        .fifo_en        (fifo_en),
        .rx_trig        (rx_trig),
        .tx_trig        (tx_trig),
        .rx_level       (rx_level),
        .tx_level       (tx_level),
        .tx_shift_empty (tx_shift_empty),
        .thr_wait_shift (thr_wait_shift),
        .rx_hit         (rx_hit),
        .tx_room        (tx_room)
    );

    always_comb begin
        ack_thr  = rd_iir && (iir_q[5:0] == IID_THR);
        ack_xoff = rd_iir && (iir_q[5:0] == IID_XOFF);
        ack_flow = rd_iir && (iir_q[5:0] == IID_FLOW);
        line_d   = lsr_err  | (line_q  & ~rd_lsr);
        modem_d  = msr_chg  | (modem_q & ~rd_msr);
        xoff_d   = xoff_evt | (xoff_q  & ~ack_xoff);
        flow_d   = flow_evt | (flow_q  & ~ack_flow);
    end

    uirq_thr_fsm u_thr (
        .clk       (clk),
        .rst_n     (rst_n),
        .room      (tx_room),
        .ack       (ack_thr),
        .pend_next (thr_pend)
    );

    always_comb begin
        req             = '0;
        req[SRC_LINE]   = line_d     & irq_en[2];
        req[SRC_RXTO]   = rx_timeout & irq_en[0];
        req[SRC_RXDATA] = rx_hit     & irq_en[0];
        req[SRC_THR]    = thr_pend   & irq_en[1];
        req[SRC_MODEM]  = modem_d    & irq_en[3];
        req[SRC_XOFF]   = xoff_d     & irq_en[4];
        req[SRC_FLOW]   = flow_d     & irq_en[5];
    end

    uirq_prio u_prio (
        .req  (req),
        .code (code)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q  <= 1'b0;
            modem_q <= 1'b0;
            xoff_q  <= 1'b0;
            flow_q  <= 1'b0;
            iir_q   <= 8'h01;
            irq_q   <= 1'b0;
            seen_q  <= 1'b0;
        end else begin
            line_q  <= line_d;
            modem_q <= modem_d;
            xoff_q  <= xoff_d;
            flow_q  <= flow_d;
            iir_q   <= {fifo_en, fifo_en, code};
            irq_q   <= ~code[0];
            seen_q  <= 1'b1;
        end
    end

    assign iir = iir_q;
    assign irq = irq_q;

    AST_FIFO_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (iir[7:6] == {2{$past(fifo_en)}})); // R3

    AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_err && irq_en[2]) |=> (iir[5:0] == IID_LINE)); // R4

    AST_LSR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lsr && !lsr_err) |=> (iir[5:0] != IID_LINE)); // R10

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 6'h00) |=> !irq); // R13

endmodule

// File: tb/uirq_ident_bench.sv
module uirq_ident_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LVL_W      = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [5:0]       irq_en = '0;
    logic             fifo_en = 1'b0;
    logic [1:0]       rx_trig = '0;
    logic [1:0]       tx_trig = '0;
    logic [LVL_W-1:0] rx_level = '0;
    logic [LVL_W-1:0] tx_level = 7'd64;
    logic             tx_shift_empty = 1'b0;
    logic             thr_wait_shift = 1'b0;
    logic             rx_timeout = 1'b0;
    logic             lsr_err = 1'b0;
    logic             msr_chg = 1'b0;
    logic             xoff_evt = 1'b0;
    logic             flow_evt = 1'b0;
    logic             rd_iir = 1'b0;
    logic             rd_lsr = 1'b0;
    logic             rd_msr = 1'b0;
    logic [7:0]       iir;
    logic             irq;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    logic       m_line, m_modem, m_xoff, m_flow;
    int         m_thr;  // 0 busy, 1 pending, 2 acknowledged
    logic [7:0] m_iir;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uirq_ident u_uirq_ident (
        .clk (clk), .rst_n (rst_n), .irq_en (irq_en), .fifo_en (fifo_en),
        .rx_trig (rx_trig), .tx_trig (tx_trig), .rx_level (rx_level),
        .tx_level (tx_level), .tx_shift_empty (tx_shift_empty),
        .thr_wait_shift (thr_wait_shift), .rx_timeout (rx_timeout),
        .lsr_err (lsr_err), .msr_chg (msr_chg), .xoff_evt (xoff_evt),
        .flow_evt (flow_evt), .rd_iir (rd_iir), .rd_lsr (rd_lsr),
        .rd_msr (rd_msr), .iir (iir), .irq (irq)
    );

    function automatic int rx_thr_of(input logic [1:0] t);
        case (t)
            2'd0: return 8;
            2'd1: return 16;
            2'd2: return 56;
            default: return 60;
        endcase
    endfunction

    function automatic int tx_thr_of(input logic [1:0] t);
        case (t)
            2'd0: return 8;
            2'd1: return 16;
            2'd2: return 32;
            default: return 56;
        endcase
    endfunction

    function automatic logic exp_rx_hit();
        if (fifo_en) return int'(rx_level) >= rx_thr_of(rx_trig);
        return rx_level != 0;
    endfunction

    function automatic logic exp_tx_room();
        if (thr_wait_shift) return (tx_level == 0) && tx_shift_empty;
        if (fifo_en) return (64 - int'(tx_level)) >= tx_thr_of(tx_trig);
        return tx_level == 0;
    endfunction

    task automatic model_step();
        logic [5:0] shown;
        logic room;
        logic [5:0] c;
        shown = m_iir[5:0];
        room  = exp_tx_room();
        if (!room) m_thr = 0;
        else if (m_thr == 0) m_thr = 1;
        else if (m_thr == 1 && rd_iir && shown == 6'h02) m_thr = 2;
        m_line  = lsr_err  | (m_line  & ~rd_lsr);
        m_modem = msr_chg  | (m_modem & ~rd_msr);
        m_xoff  = xoff_evt | (m_xoff  & ~(rd_iir && shown == 6'h10));
        m_flow  = flow_evt | (m_flow  & ~(rd_iir && shown == 6'h20));
        if (m_line && irq_en[2])                    c = 6'h06;
        else if (rx_timeout && irq_en[0])           c = 6'h0C;
        else if (exp_rx_hit() && irq_en[0])         c = 6'h04;
        else if (m_thr == 1 && irq_en[1])           c = 6'h02;
        else if (m_modem && irq_en[3])              c = 6'h00;
        else if (m_xoff && irq_en[4])               c = 6'h10;
        else if (m_flow && irq_en[5])               c = 6'h20;
        else                                        c = 6'h01;
        m_iir = {fifo_en, fifo_en, c};
    endtask

    task automatic check(input string tag, input logic [8:0] got, input logic [8:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got iir/irq=%h expected %h", tag, got, exp);
        end
    endtask

    // one clock: model advances at the edge, outputs compared mid-cycle
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("R4 model", {iir, irq}, {m_iir, ~m_iir[0]});
    endtask

    task automatic expect_iir(input string tag, input logic [7:0] e);
        check(tag, {iir, irq}, {e, ~e[0]});
    endtask

    task automatic clear_strobes();
        lsr_err = 0; msr_chg = 0; xoff_evt = 0; flow_evt = 0;
        rd_iir = 0; rd_lsr = 0; rd_msr = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_line = 0; m_modem = 0; m_xoff = 0; m_flow = 0; m_thr = 0; m_iir = 8'h01;
        repeat (3) @(negedge clk);
        expect_iir("R1 reset", 8'h01);
        rst_n = 1;
        cyc();
        expect_iir("R1 idle after reset", 8'h01);

        // R5 receive threshold, FIFO mode, code 3
        fifo_en = 1; irq_en = 6'h01; rx_trig = 2'd3; rx_level = 7'd59;
        cyc(); expect_iir("R3 R5 below threshold", 8'hC1);
        rx_level = 7'd60;
        cyc(); expect_iir("R2 R5 at threshold", 8'hC4);
        // R5 non-FIFO mode
        fifo_en = 0; rx_level = 7'd1;
        cyc(); expect_iir("R3 R5 non-fifo any data", 8'h04);
        rx_level = 0; fifo_en = 1;
        // R6 timeout
        rx_timeout = 1;
        cyc(); expect_iir("R6 timeout", 8'hCC);
        rx_timeout = 0;
        cyc();

        // R7 transmit room, code 3 = 56 spaces
        irq_en = 6'h02; tx_trig = 2'd3; tx_level = 7'd9;
        cyc(); expect_iir("R7 55 spaces", 8'hC1);
        tx_level = 7'd8;
        cyc(); expect_iir("R7 56 spaces", 8'hC2);
        rd_iir = 1;
        cyc(); expect_iir("R9 acknowledged", 8'hC1);
        rd_iir = 0;
        cyc(); expect_iir("R9 stays quiet", 8'hC1);
        tx_level = 7'd20;
        cyc();
        tx_level = 7'd8;
        cyc(); expect_iir("R9 rearmed", 8'hC2);
        // R8 wait for shift register
        thr_wait_shift = 1; tx_level = 0; tx_shift_empty = 0;
        cyc(); expect_iir("R8 shift busy", 8'hC1);
        tx_shift_empty = 1;
        cyc(); expect_iir("R8 shift empty", 8'hC2);
        thr_wait_shift = 0; tx_level = 7'd64; tx_shift_empty = 0;
        cyc();

        // R4 R10 line error over timeout
        irq_en = 6'h3F; rx_timeout = 1; lsr_err = 1;
        cyc(); expect_iir("R4 line over timeout", 8'hC6);
        lsr_err = 0;
        cyc(); expect_iir("R10 line held", 8'hC6);
        rd_lsr = 1;
        cyc(); expect_iir("R10 line read clears", 8'hCC);
        rd_lsr = 0; lsr_err = 1; rd_lsr = 1;
        cyc(); expect_iir("R10 set wins over read", 8'hC6);
        clear_strobes(); rd_lsr = 1; rx_timeout = 0;
        cyc(); expect_iir("R10 cleared", 8'hC1);
        rd_lsr = 0;

        // R11 modem
        msr_chg = 1;
        cyc(); expect_iir("R11 modem code 00", 8'hC0);
        msr_chg = 0;
        cyc(); expect_iir("R11 modem held", 8'hC0);
        rd_msr = 1;
        cyc(); expect_iir("R11 modem read clears", 8'hC1);
        rd_msr = 0;

        // R12 XOFF then flow
        xoff_evt = 1; flow_evt = 1;
        cyc(); expect_iir("R12 xoff over flow", 8'hD0);
        clear_strobes(); rd_iir = 1;
        cyc(); expect_iir("R12 xoff acked, flow shown", 8'hE0);
        cyc(); expect_iir("R12 flow acked", 8'hC1);
        rd_iir = 0;

        // R13 gating keeps held state
        irq_en = 6'h00; lsr_err = 1;
        cyc(); expect_iir("R13 disabled quiet", 8'hC1);
        lsr_err = 0;
        cyc(); expect_iir("R13 still quiet", 8'hC1);
        irq_en = 6'h04;
        cyc(); expect_iir("R13 re-enabled shows held", 8'hC6);
        rd_lsr = 1;
        cyc();
        rd_lsr = 0;

        // random phase against the model
        for (int k = 0; k < 4000; k++) begin
            irq_en         = 6'($urandom);
            fifo_en        = ($urandom_range(7, 0) != 0);
            rx_trig        = 2'($urandom);
            tx_trig        = 2'($urandom);
            rx_level       = 7'($urandom_range(64, 0));
            tx_level       = 7'($urandom_range(64, 0));
            tx_shift_empty = 1'($urandom);
            thr_wait_shift = ($urandom_range(3, 0) == 0);
            rx_timeout     = ($urandom_range(7, 0) == 0);
            lsr_err        = ($urandom_range(15, 0) == 0);
            msr_chg        = ($urandom_range(15, 0) == 0);
            xoff_evt       = ($urandom_range(15, 0) == 0);
            flow_evt       = ($urandom_range(15, 0) == 0);
            rd_iir         = ($urandom_range(3, 0) == 0);
            rd_lsr         = ($urandom_range(7, 0) == 0);
            rd_msr         = ($urandom_range(7, 0) == 0);
            cyc();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule